// File: doc/BRIEF.md
# Embedded Operation Status Reporter

This block produces the word a flash memory returns on a read while one of its internal program or erase sequences is running. While the operation is in flight, array read data is replaced by a status word. That word carries a data-polling bit, a read-driven toggle bit, a time-limit-exceeded bit, and a second toggle bit that separates the sector being erased from the other sectors. When no operation is running, array data passes through unchanged, and a ready output tells the host whether the part can take new work.

The toggle bits advance on read strobes, not on clock cycles. A host that polls twice and sees a difference knows that the operation is still running. Both toggle states return to a fixed value whenever the part is idle, so the first two reads of every operation always differ. The block has no array, no command decoder and no algorithm timer. Its neighbours supply the busy flag, the operation type, the data being written, a sector-match flag for the current read address, and the time-limit flag.

Top module: `flash_status_rpt`

## Requirements
- R1: While `op_busy` is 0, `rd_data` equals `array_q` and `ready` is 1.
- R2: While `op_busy` is 1, `ready` is 0 and `rd_data` carries the status word instead of array data.
- R3: During a program operation (`op_erase`=0), status bit 7 is the inverse of bit 7 of `prog_data`.
- R4: During an erase operation (`op_erase`=1), status bit 7 reads 0.
- R5: Status bit 6 reads 0 on the first read strobe of an operation. It inverts after every read strobe taken while `op_busy` is 1, and the new value is visible from the next cycle.
- R6: Status bit 6 and status bit 2 keep their value in cycles without a read strobe.
- R7: Status bit 2 reads 0 at the start of an operation. It inverts after a read strobe only during an erase with `sect_hit`=1, and it stays constant for reads during a program or reads with `sect_hit`=0.
- R8: Status bit 5 reads 1 from the cycle `time_over` is seen with `op_busy`=1 until `op_busy` falls. It reads 0 in any operation that has not seen `time_over`.
- R9: Status bits 4, 3, 1 and 0 read 0, and bits 6..0 of `prog_data` have no effect on the status word.
- R10: Reset, or any cycle with `op_busy`=0, returns both toggle states and the time-limit flag to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_busy | input | 1 | An embedded program or erase is running |
| op_erase | input | 1 | Operation type: 1 for erase, 0 for program |
| prog_data | input | DW | Data being programmed |
| time_over | input | 1 | The operation has exceeded its time limit |
| rd_stb | input | 1 | One-cycle read access strobe |
| sect_hit | input | 1 | The read address falls in a sector being erased |
| array_q | input | DW | Array read data |
| rd_data | output | DW | Read data: array data when idle, status word when busy |
| ready | output | 1 | 1 when no operation is running |

## Verification
The hardest state to reach is one where the two toggle states have drifted apart within a single erase. That happens only when reads with and without a sector match are interleaved, so that bit 2 and bit 6 differ, and it has to be seen together with a latched time-limit flag that outlives its input pulse. The vector table builds that history step by step in one erase. It mixes matched, unmatched and strobe-free cycles, and then ends the operation to show that every piece of state clears. A directed test then resets the block in the middle of an operation, which checks that the toggle restarts at its fixed value.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  // Positions of the status bits in the returned word
  localparam int unsigned POLL_BIT   = 7;
  localparam int unsigned TOGA_BIT   = 6;
  localparam int unsigned LIMIT_BIT  = 5;
  localparam int unsigned TOGB_BIT   = 2;
  localparam int unsigned STATUS_MIN = 8;

  // Index of each toggle cell
  localparam int unsigned TOG_ANY    = 0;
  localparam int unsigned TOG_SECT   = 1;
  localparam int unsigned TOG_COUNT  = 2;
endpackage

// File: rtl/stat_toggle.sv
module stat_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic adv,
  output logic tog_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tog_q <= 1'b0;
    else if (!run)   tog_q <= 1'b0;
    else if (adv)    tog_q <= ~tog_q;
  end

  // R5: an advancing read inverts the state while the operation continues
  assert_flip_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && adv) |=> (!run || tog_q != $past(tog_q)));

  // R6: no advance, no change
  assert_hold_no_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !adv) |=> (!run || $stable(tog_q)));
endmodule

// File: rtl/stat_limit.sv
module stat_limit (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic over,
  output logic flag
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            seen_q <= 1'b0;
    else if (!run)         seen_q <= 1'b0;
    else if (over)         seen_q <= 1'b1;
  end

  assign flag = run && (seen_q || over);

  // R8: once reported, the flag persists until the operation ends
  assert_limit_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && over) |=> (!run || flag));
endmodule

// File: rtl/stat_encode.sv
module stat_encode
  import flash_status_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          busy,
  input  logic          erase,
  input  logic          data_msb,
  input  logic          tog_any,
  input  logic          tog_sect,
  input  logic          limit,
  input  logic [DW-1:0] array_q,
  output logic [DW-1:0] word
);
  logic [DW-1:0] status;

  always_comb begin
    status            = '0;
    status[POLL_BIT]  = erase ? 1'b0 : ~data_msb;
    status[TOGA_BIT]  = tog_any;
    status[LIMIT_BIT] = limit;
    status[TOGB_BIT]  = tog_sect;
  end

  assign word = busy ? status : array_q;
endmodule

// File: rtl/flash_status_rpt.sv
module flash_status_rpt
  import flash_status_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_busy,
  input  logic          op_erase,
  input  logic [DW-1:0] prog_data,
  input  logic          time_over,
  input  logic          rd_stb,
  input  logic          sect_hit,
  input  logic [DW-1:0] array_q,
  output logic [DW-1:0] rd_data,
  output logic          ready
);
  localparam int unsigned MSB = DW - 1;

  logic [TOG_COUNT-1:0] adv;
  logic [TOG_COUNT-1:0] tog;
  logic                 limit;

  initial begin
    if (DW < STATUS_MIN) $error("DW must hold the status bits");
  end

  always_comb begin
    adv           = '0;
    adv[TOG_ANY]  = rd_stb;
    adv[TOG_SECT] = rd_stb && sect_hit && op_erase;
  end

  for (genvar g = 0; g < TOG_COUNT; g++) begin : g_tog
    stat_toggle u_tog (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (op_busy),
      .adv   (adv[g]),
      .tog_q (tog[g])
    );
  end

  stat_limit u_limit (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (op_busy),
    .over  (time_over),
    .flag  (limit)
  );

  stat_encode #(.DW(DW)) u_enc (
    .busy     (op_busy),
    .erase    (op_erase),
    .data_msb (prog_data[MSB]),
    .tog_any  (tog[TOG_ANY]),
    .tog_sect (tog[TOG_SECT]),
    .limit    (limit),
    .array_q  (array_q),
    .word     (rd_data)
  );

  assign ready = ~op_busy;

  // R1: idle reads pass array data
  assert_idle_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_busy) |-> (rd_data == array_q && ready));

  // R2: busy withdraws ready
  assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op_busy |-> !ready);

  // R4: erase polls as zero
  assert_erase_poll_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy && op_erase) |-> !rd_data[POLL_BIT]);

  // R7: sector toggle holds during a program
  assert_sect_hold_prog_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_busy && !op_erase) |=> (!op_busy || $stable(rd_data[TOGB_BIT])));
endmodule

// File: tb/tb_flash_status_rpt.sv
module tb_flash_status_rpt;
  localparam int DW = 8;
  localparam int NV = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_busy = 1'b0;
  logic          op_erase = 1'b0;
  logic [DW-1:0] prog_data = '0;
  logic          time_over = 1'b0;
  logic          rd_stb = 1'b0;
  logic          sect_hit = 1'b0;
  logic [DW-1:0] array_q = '0;
  logic [DW-1:0] rd_data;
  logic          ready;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  flash_status_rpt #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .op_busy(op_busy), .op_erase(op_erase),
    .prog_data(prog_data), .time_over(time_over), .rd_stb(rd_stb),
    .sect_hit(sect_hit), .array_q(array_q), .rd_data(rd_data), .ready(ready)
  );

  // {busy, erase, tmo, rd, hit, pdata[8], arr[8], exp[8], exp_rdy, req[4]}
  localparam logic [33:0] VEC [NV] = '{
    {5'b00010, 8'h00, 8'h3C, 8'h3C, 1'b1, 4'd1},   // R1 idle pass
    {5'b10010, 8'h80, 8'h00, 8'h00, 1'b0, 4'd3},   // R3 poll = ~1, first toggle 0
    {5'b10010, 8'h80, 8'h00, 8'h40, 1'b0, 4'd5},   // R5 toggle inverted
    {5'b10000, 8'h80, 8'h00, 8'h00, 1'b0, 4'd6},   // R6 no read
    {5'b10000, 8'h80, 8'h00, 8'h00, 1'b0, 4'd6},   // R6 still held
    {5'b10010, 8'h80, 8'h00, 8'h00, 1'b0, 4'd5},   // R5 read
    {5'b10011, 8'h00, 8'h00, 8'hC0, 1'b0, 4'd7},   // R7 program hit: bit2 stays
    {5'b10011, 8'h00, 8'h00, 8'h80, 1'b0, 4'd7},   // R7 again
    {5'b00000, 8'h00, 8'hA5, 8'hA5, 1'b1, 4'd1},   // R1 idle
    {5'b11011, 8'h00, 8'h00, 8'h00, 1'b0, 4'd10},  // R10 fresh erase, R4
    {5'b11010, 8'h00, 8'h00, 8'h44, 1'b0, 4'd7},   // R7 no hit
    {5'b11011, 8'h00, 8'h00, 8'h04, 1'b0, 4'd7},   // R7 hit
    {5'b11111, 8'h00, 8'h00, 8'h60, 1'b0, 4'd8},   // R8 limit seen
    {5'b11000, 8'h00, 8'h00, 8'h24, 1'b0, 4'd8},   // R8 sticky
    {5'b00000, 8'h00, 8'h5A, 8'h5A, 1'b1, 4'd1},   // R1 idle
    {5'b10000, 8'h7F, 8'h00, 8'h80, 1'b0, 4'd9}    // R9 low data bits ignored, R8 cleared
  };

  task automatic check(input string tag, input logic [DW-1:0] exp_d, input logic exp_r);
    total++;
    if (rd_data !== exp_d) begin
      bad++;
      $display("FAIL %s data: actual=%h expected=%h", tag, rd_data, exp_d);
    end
    total++;
    if (ready !== exp_r) begin
      bad++;
      $display("FAIL %s ready: actual=%b expected=%b", tag, ready, exp_r);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset state: R10, R1
    check("R10 reset idle", 8'h00, 1'b1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {op_busy, op_erase, time_over, rd_stb, sect_hit} = VEC[i][33:29];
      prog_data = VEC[i][28:21];
      array_q   = VEC[i][20:13];
      #1;
      check($sformatf("R%0d vec%0d", VEC[i][3:0], i), VEC[i][12:5], VEC[i][4]);
    end

    // R2: busy with no read, bits set only by poll
    @(negedge clk);
    op_busy = 1'b1; op_erase = 1'b0; prog_data = 8'h00; rd_stb = 1'b0; time_over = 1'b0;
    #1;
    check("R2 busy", 8'h80, 1'b0);

    // R10: reset in the middle of an erase restarts the toggle
    @(negedge clk);
    op_erase = 1'b1; rd_stb = 1'b1; sect_hit = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    #1;
    check("R5 erase after one read", 8'h44, 1'b0);
    rst_n = 1'b0;
    #1;
    check("R10 reset mid-op", 8'h00, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    rd_stb = 1'b1;
    #1;
    check("R10 first read after reset", 8'h00, 1'b0);
    @(negedge clk);
    #1;
    check("R5 second read after reset", 8'h44, 1'b0);
    @(negedge clk);
    op_busy = 1'b0; rd_stb = 1'b0; array_q = 8'hE1;
    #1;
    check("R1 final idle", 8'hE1, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule